// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This is the multiply and accumulate execution stage of a 32-bit processor. It holds two signed 64-bit accumulators. One strobed operation per cycle takes two 32-bit register operands and writes, adds or subtracts a signed product into one of the accumulators. A per-operation select bit picks the accumulator for the four word-by-halfword operations. The word operations use the whole first operand as a signed 32-bit value and one signed 16-bit half of the second operand.

A fifth operation multiplies the low halves of both operands. It scales that product up by 2^16 and subtracts it from accumulator 0. The result is folded into a 56-bit signed range. Both accumulators are always visible on read-back ports. A new value appears after the clock edge that samples the strobe.

Top module: `dmac_unit`

## Requirements
- R1: After reset, both accumulator outputs read zero.
- R2: Opcodes 0 (multiply-high) and 2 (multiply-accumulate-high) multiply `src_a`, taken as signed 32-bit, by `src_b[31:16]`, taken as signed 16-bit.
- R3: Opcodes 1 (multiply-low) and 3 (multiply-accumulate-low) multiply signed `src_a` by `src_b[15:0]`, taken as signed 16-bit.
- R4: Opcodes 0 and 1 overwrite the target accumulator with the signed product, sign-extended to 64 bits.
- R5: Opcodes 2 and 3 add the signed product to the target accumulator's current value and store the 64-bit sum, wrapping modulo 2^64.
- R6: For opcodes 0 to 3, `acc_sel` = 0 targets accumulator 0 and `acc_sel` = 1 targets accumulator 1.
- R7: Opcode 4 (multiply-subtract-low) forms the signed product of `src_a[15:0]` and `src_b[15:0]` and keeps its low 32 bits as a signed value. It shifts that value left by 16 and subtracts it from accumulator 0, whatever `acc_sel` is.
- R8: The opcode-4 result is stored sign-extended from bit 55, so bits 63:56 of accumulator 0 equal its bit 55.
- R9: A valid operation leaves the accumulator it does not target unchanged.
- R10: While `op_valid` is low, neither accumulator changes. A valid operation's result appears on the output after the next rising clock edge.
- R11: Valid operations with opcodes 5, 6 or 7 change neither accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 to 4 legal) |
| acc_sel | input | 1 | Target accumulator for opcodes 0 to 3 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| acc0_q | output | 64 | Accumulator 0 contents |
| acc1_q | output | 64 | Accumulator 1 contents |

## Verification
The bench drives 0x80000000 against a halfword of 0x8000. A design that took the first operand as unsigned, or took the wrong half, would return a product with the wrong sign or size. It runs hundreds of back-to-back accumulations until accumulator 0 passes 2^55, then issues a multiply-subtract. A design without the 56-bit fold would keep stray upper bits there. A design that folded the accumulate forms as well would truncate the running sum. Multiply-subtract is issued with `acc_sel` high and the illegal opcodes are issued with the strobe high. These catch a unit that writes accumulator 1 or writes on an undefined code. A per-cycle reference model is compared on both read-back ports, so a result that appears a cycle late or touches the untargeted accumulator is reported.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = 16;
  localparam int ACC_W   = 64;
  localparam int WRAP_W  = 56;
  localparam int SUB_SHL = 16;
  localparam int NUM_ACC = 2;
  localparam int SEL_W   = $clog2(NUM_ACC);

  typedef enum logic [2:0] {
    OP_MULW_HI = 3'd0,
    OP_MULW_LO = 3'd1,
    OP_MACW_HI = 3'd2,
    OP_MACW_LO = 3'd3,
    OP_MSUB_LO = 3'd4
  } dmac_op_e;

  // signed word times signed halfword, extended to accumulator width
  function automatic logic signed [ACC_W-1:0] f_word_prod(
    input logic [DATA_W-1:0] a, input logic [HALF_W-1:0] h);
    logic signed [ACC_W-1:0] ea;
    logic signed [ACC_W-1:0] eh;
    ea = {{(ACC_W-DATA_W){a[DATA_W-1]}}, a};
    eh = {{(ACC_W-HALF_W){h[HALF_W-1]}}, h};
    return ea * eh;
  endfunction

  // halfword-by-halfword product, low 2*HALF_W bits kept signed, scaled up
  function automatic logic [ACC_W-1:0] f_sub_term(
    input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b);
    logic signed [2*HALF_W-1:0] ea;
    logic signed [2*HALF_W-1:0] eb;
    logic signed [2*HALF_W-1:0] p;
    ea = {{HALF_W{a[HALF_W-1]}}, a};
    eb = {{HALF_W{b[HALF_W-1]}}, b};
    p  = ea * eb;
    return {{(ACC_W-2*HALF_W){p[2*HALF_W-1]}}, p} << SUB_SHL;
  endfunction

  // fold a value to WRAP_W signed bits
  function automatic logic [ACC_W-1:0] f_wrap(input logic [ACC_W-1:0] v);
    return {{(ACC_W-WRAP_W){v[WRAP_W-1]}}, v[WRAP_W-1:0]};
  endfunction
endpackage

// File: rtl/dmac_mult.sv
module dmac_mult
  import dmac_pkg::*;
(
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              use_hi,
  output logic [ACC_W-1:0]  word_prod,
  output logic [ACC_W-1:0]  sub_term
);
  logic [HALF_W-1:0] b_half;

  assign b_half    = use_hi ? src_b[DATA_W-1:DATA_W-HALF_W] : src_b[HALF_W-1:0];
  assign word_prod = f_word_prod(src_a, b_half);
  assign sub_term  = f_sub_term(src_a[HALF_W-1:0], src_b[HALF_W-1:0]);
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine
  import dmac_pkg::*;
(
  input  logic [2:0]       op_code,
  input  logic [ACC_W-1:0] cur_acc,
  input  logic [ACC_W-1:0] word_prod,
  input  logic [ACC_W-1:0] sub_term,
  output logic [ACC_W-1:0] next_acc
);
  logic [ACC_W-1:0] diff;

  assign diff = cur_acc - sub_term;

  always_comb begin
    unique case (op_code)
      OP_MULW_HI, OP_MULW_LO: next_acc = word_prod;
      OP_MACW_HI, OP_MACW_LO: next_acc = cur_acc + word_prod;
      OP_MSUB_LO:             next_acc = f_wrap(diff);
      default:                next_acc = cur_acc;
    endcase
  end
endmodule

// File: rtl/dmac_acc_bank.sv
module dmac_acc_bank
  import dmac_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ACC-1:0]            wr_en,
  input  logic [ACC_W-1:0]              wr_data,
  output logic [NUM_ACC-1:0][ACC_W-1:0] acc_q
);
  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n)        acc_q[k] <= '0;
      else if (wr_en[k]) acc_q[k] <= wr_data;
    end
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              acc_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [ACC_W-1:0]  acc0_q,
  output logic [ACC_W-1:0]  acc1_q
);
  logic                          is_word_op;
  logic                          is_msub_op;
  logic                          legal_fire;
  logic [SEL_W-1:0]              target;
  logic [NUM_ACC-1:0]            wr_en;
  logic [NUM_ACC-1:0][ACC_W-1:0] acc_q;
  logic [ACC_W-1:0]              cur_acc;
  logic [ACC_W-1:0]              word_prod;
  logic [ACC_W-1:0]              sub_term;
  logic [ACC_W-1:0]              next_acc;

  assign is_word_op = (op_code <= 3'(OP_MACW_LO));
  assign is_msub_op = (op_code == 3'(OP_MSUB_LO));
  assign legal_fire = op_valid && (is_word_op || is_msub_op);
  assign target     = is_msub_op ? SEL_W'(0) : SEL_W'(acc_sel);
  assign cur_acc    = acc_q[target];

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_we
    assign wr_en[k] = legal_fire && (target == SEL_W'(k));
  end

  dmac_mult u_mult (
    .src_a    (src_a),
    .src_b    (src_b),
    .use_hi   (~op_code[0]),
    .word_prod(word_prod),
    .sub_term (sub_term)
  );

  dmac_combine u_combine (
    .op_code  (op_code),
    .cur_acc  (cur_acc),
    .word_prod(word_prod),
    .sub_term (sub_term),
    .next_acc (next_acc)
  );

  dmac_acc_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(next_acc),
    .acc_q  (acc_q)
  );

  assign acc0_q = acc_q[0];
  assign acc1_q = acc_q[1];

  // R10: no strobe, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc0_q) && $stable(acc1_q)));

  // R11: undefined codes write nothing
  a_r11_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 3'd4) |=> ($stable(acc0_q) && $stable(acc1_q)));

  // R7, R9: subtract form never touches accumulator 1
  a_r7_msub_acc1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> $stable(acc1_q));

  // R8: subtract result lies in the 56-bit signed range
  a_r8_msub_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=>
      (acc0_q[63:55] == '0 || acc0_q[63:55] == '1));

  // R4: plain multiply result fits a signed 48-bit value
  a_r4_mul_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd1 && !acc_sel) |=>
      (acc0_q[63:47] == '0 || acc0_q[63:47] == '1));

  // R9: word op on accumulator 0 leaves accumulator 1 alone, and vice versa
  a_r9_other_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd3 && !acc_sel) |=> $stable(acc1_q));
  a_r9_other_hold1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd3 && acc_sel) |=> $stable(acc0_q));
endmodule

// File: tb/dmac_unit_bench.sv
module dmac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic        acc_sel;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [63:0] acc0_q;
  logic [63:0] acc1_q;

  int     checks = 0;
  int     errors = 0;
  bit     done   = 1'b0;
  longint model [2];
  string  tag [2];

  always #10 clk = ~clk;

  dmac_unit u_dmac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .src_a(src_a), .src_b(src_b),
    .acc0_q(acc0_q), .acc1_q(acc1_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    check({tag[0], " acc0"}, acc0_q, model[0]);
    check({tag[1], " acc1"}, acc1_q, model[1]);
  endtask

  // behavioural reference: applies one operation to the model
  task automatic apply(input bit v, input logic [2:0] op, input bit sel,
                       input logic [31:0] a, input logic [31:0] b);
    longint prod;
    longint term;
    int     low32;
    logic [15:0] half;
    tag[0] = "R10"; tag[1] = "R10";
    if (v) begin
      if (op <= 3) begin
        half = op[0] ? b[15:0] : b[31:16];
        prod = longint'($signed(a)) * longint'($signed(half));
        if (op <= 1) model[sel] = prod;
        else         model[sel] = model[sel] + prod;
        tag[sel]  = op[0] ? (op <= 1 ? "R3 R4 R6" : "R3 R5 R6")
                          : (op <= 1 ? "R2 R4 R6" : "R2 R5 R6");
        tag[!sel] = "R9";
      end else if (op == 4) begin
        prod  = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        low32 = int'(prod);
        term  = longint'(low32) * 65536;
        model[0] = model[0] - term;
        model[0] = (model[0] <<< 8) >>> 8;
        tag[0] = "R7 R8";
        tag[1] = "R9";
      end else begin
        tag[0] = "R11"; tag[1] = "R11";
      end
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input bit sel,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    compare();
    op_valid = v; op_code = op; acc_sel = sel; src_a = a; src_b = b;
    apply(v, op, sel, a, b);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_8000;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_sel = 1'b0;
    src_a = '0; src_b = '0;
    model[0] = 0; model[1] = 0;
    // R1: reset holds both accumulators at zero, even with a strobe present
    repeat (2) @(negedge clk);
    op_valid = 1'b1; op_code = 3'd2; src_a = 32'h1234_5678; src_b = 32'h7FFF_7FFF;
    @(negedge clk);
    check("R1 acc0", acc0_q, 64'd0);
    check("R1 acc1", acc1_q, 64'd0);
    op_valid = 1'b0;
    rst_n = 1'b1;
    tag[0] = "R1"; tag[1] = "R1";

    // R2/R3 sign corners
    step(1, 3'd0, 0, 32'h8000_0000, 32'h8000_0001);
    step(1, 3'd1, 1, 32'h8000_0000, 32'h0001_8000);
    step(1, 3'd2, 0, 32'hFFFF_FFFF, 32'h7FFF_0000);
    step(1, 3'd3, 1, 32'h7FFF_FFFF, 32'hABCD_7FFF);
    // R10 idle with live operands
    step(0, 3'd2, 1, 32'h1111_1111, 32'h2222_2222);
    // R11 illegal codes
    step(1, 3'd5, 0, 32'h7FFF_FFFF, 32'h7FFF_7FFF);
    step(1, 3'd6, 1, 32'h7FFF_FFFF, 32'h7FFF_7FFF);
    step(1, 3'd7, 0, 32'h7FFF_FFFF, 32'h7FFF_7FFF);
    // R7: subtract ignores acc_sel
    step(1, 3'd4, 1, 32'h0000_8000, 32'h0000_8000);
    step(1, 3'd4, 0, 32'h0000_7FFF, 32'hFFFF_8000);
    // R5/R8: push accumulator 0 past 2^55, then subtract to force the fold
    step(1, 3'd0, 0, 32'h0000_0000, 32'h0000_0000);
    for (int i = 0; i < 600; i++)
      step(1, 3'd2, 0, 32'h7FFF_FFFF, 32'h7FFF_0000);
    step(1, 3'd4, 1, 32'h0000_0003, 32'h0000_0005);
    // same wrap in the negative direction
    step(1, 3'd0, 0, 32'h0000_0000, 32'h0000_0000);
    for (int i = 0; i < 600; i++)
      step(1, 3'd3, 0, 32'h8000_0000, 32'h0000_7FFF);
    step(1, 3'd4, 0, 32'h0000_0002, 32'h0000_0007);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), pick(), pick());
    step(0, 3'd0, 0, 32'h0, 32'h0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule